// File: doc/BRIEF.md
# USB Control Endpoint Handshake Controller

This block decides the handshake a device returns on one USB control endpoint and keeps that endpoint's interrupt flags. The packet layer gives it single-cycle token events: a SETUP packet was received, an OUT data packet arrived, or an IN token arrived. A retry-needed line from the same layer accompanies each event. Firmware sets or clears a stall request, pulses one clear strobe per flag, and chooses which flags may raise the endpoint interrupt.

For each event the block answers in the same cycle with one of four handshakes. Five flags record what happened:

- a SETUP packet was taken,
- an OUT packet was taken,
- the IN bank is free,
- an IN token was answered with NAK,
- a STALL was returned.

In a control write, the NAK-on-IN flag tells firmware that the host has moved to the status stage.

A SETUP packet is always accepted. It cancels any pending stall request, so firmware that rejects a request only has to ask for a stall and then wait for the next SETUP. The two bank-control bits of a generic endpoint have no meaning here and always read as zero.

Top module: `usb_ctrl_ep_hs`

## Requirements
- R1: A SETUP event (`setup_rx_i`) is answered with ACK (`hs_o` = 2'b00). This holds whatever the stall request, retry or flag state. If SETUP arrives together with other events, SETUP is the one served. Among the others, OUT is served before IN.
- R2: A SETUP sets flag bit 0 (setup received) on the next edge. On the same edge it clears the stall request and flag bit 4 (stalled). It leaves flag bit 1 (OUT received) unchanged.
- R3: An OUT or IN event that carries `retry_i` is answered with NAK (`hs_o` = 2'b01), even when a stall is requested.
- R4: An OUT or IN event without retry while the stall request is set is answered with STALL (`hs_o` = 2'b10). Flag bit 4 is set on the next edge.
- R5: An OUT event with no stall and no retry is answered with ACK when flag bits 0 and 1 are both clear, and flag bit 1 is then set. Otherwise it is answered with NAK.
- R6: An IN event with no stall and no retry is answered with DATA (`hs_o` = 2'b11) when flag bit 2 (IN bank free) is clear, and flag bit 2 is then set again. While flag bit 2 is set, the IN event gets NAK instead, and flag bit 3 (IN NAKed) is set. Flag bit 3 is also set when an IN event is NAKed because of retry.
- R7: The clear strobes and the stall-request writes act on the next edge. When hardware sets a flag in the same cycle as firmware clears it, the set wins. A stall set together with a stall clear leaves the request set.
- R8: `irq_o` is high exactly when some flag and its enable bit in `irq_en_i` are both set.
- R9: `fifo_ctrl_o` and `rw_allowed_o` always read as zero.
- R10: After reset, flag bit 2 is set, all other flags are clear, and the stall request is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_rx_i | input | 1 | SETUP packet received (one-cycle event) |
| out_rx_i | input | 1 | OUT data packet received (one-cycle event) |
| in_tok_i | input | 1 | IN token received (one-cycle event) |
| retry_i | input | 1 | Packet layer needs a retry for this event |
| stall_set_i | input | 1 | Firmware sets the stall request |
| stall_clr_i | input | 1 | Firmware clears the stall request |
| flag_clr_i | input | 5 | Per-flag clear strobes (bit order as flags_o) |
| irq_en_i | input | 5 | Per-flag interrupt enables |
| hs_valid_o | output | 1 | A handshake is returned this cycle |
| hs_o | output | 2 | 00 ACK, 01 NAK, 10 STALL, 11 DATA |
| flags_o | output | 5 | 0 setup, 1 OUT, 2 IN bank free, 3 IN NAKed, 4 stalled |
| stall_req_o | output | 1 | Pending stall request |
| fifo_ctrl_o | output | 1 | Bank control bit, constant zero |
| rw_allowed_o | output | 1 | Read-write allowed bit, constant zero |
| irq_o | output | 1 | Endpoint interrupt |

## Verification
Several rules are checked by assertions on every cycle:

- a SETUP is always ACKed, and on the next edge it sets its flag, drops the stall state and leaves the OUT flag alone;
- retry never lets a STALL through;
- a returned STALL always raises the stalled flag;
- a busy bank never ACKs an OUT;
- a hardware set beats a same-cycle clear.

Some behaviour can only be shown by the bench's sequences, which follow the flags across several transactions. This includes the control-write flow from SETUP through DATA to a NAKed status-stage IN, the masking of the interrupt, and firmware clears that free the bank.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10,
    HS_DATA  = 2'b11
  } hs_e;

  localparam int unsigned NFLAG     = 5;
  localparam int unsigned F_SETUP   = 0;
  localparam int unsigned F_OUT     = 1;
  localparam int unsigned F_INRDY   = 2;
  localparam int unsigned F_NAKIN   = 3;
  localparam int unsigned F_STALLED = 4;
  localparam logic [NFLAG-1:0] FLAG_RST = NFLAG'(1) << F_INRDY;
endpackage

// File: rtl/usb_ep_hs_arb.sv
module usb_ep_hs_arb
  import usb_ep_pkg::*;
(
  input  logic             setup_i,
  input  logic             out_i,
  input  logic             in_i,
  input  logic             retry_i,
  input  logic             stall_req_i,
  input  logic [NFLAG-1:0] flags_i,
  output logic             hs_valid_o,
  output hs_e              hs_o,
  output logic [NFLAG-1:0] set_o
);
  logic out_busy;
  assign out_busy = flags_i[F_SETUP] | flags_i[F_OUT];

  always_comb begin
    hs_valid_o = setup_i | out_i | in_i;
    hs_o       = HS_ACK;
    set_o      = '0;
    if (setup_i) begin
      hs_o           = HS_ACK;
      set_o[F_SETUP] = 1'b1;
    end else if (out_i || in_i) begin
      if (retry_i) begin
        hs_o = HS_NAK;
        if (!out_i) set_o[F_NAKIN] = 1'b1;
      end else if (stall_req_i) begin
        hs_o             = HS_STALL;
        set_o[F_STALLED] = 1'b1;
      end else if (out_i) begin
        if (out_busy) begin
          hs_o = HS_NAK;
        end else begin
          hs_o         = HS_ACK;
          set_o[F_OUT] = 1'b1;
        end
      end else if (flags_i[F_INRDY]) begin
        hs_o           = HS_NAK;
        set_o[F_NAKIN] = 1'b1;
      end else begin
        hs_o           = HS_DATA;
        set_o[F_INRDY] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_ep_flag_bank.sv
module usb_ep_flag_bank
  import usb_ep_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  input  logic [NFLAG-1:0] wipe_i,
  output logic [NFLAG-1:0] q_o
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   q_o[g] <= FLAG_RST[g];
      else if (set_i[g])             q_o[g] <= 1'b1;
      else if (clr_i[g] | wipe_i[g]) q_o[g] <= 1'b0;
    end

    // set beats a same-cycle clear
    assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> q_o[g]);
  end
endmodule

// File: rtl/usb_ctrl_ep_hs.sv
module usb_ctrl_ep_hs
  import usb_ep_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             setup_rx_i,
  input  logic             out_rx_i,
  input  logic             in_tok_i,
  input  logic             retry_i,
  input  logic             stall_set_i,
  input  logic             stall_clr_i,
  input  logic [NFLAG-1:0] flag_clr_i,
  input  logic [NFLAG-1:0] irq_en_i,
  output logic             hs_valid_o,
  output logic [1:0]       hs_o,
  output logic [NFLAG-1:0] flags_o,
  output logic             stall_req_o,
  output logic             fifo_ctrl_o,
  output logic             rw_allowed_o,
  output logic             irq_o
);
  hs_e              hs;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_wipe;
  logic             stall_req_q;

  usb_ep_hs_arb u_arb (
    .setup_i     (setup_rx_i),
    .out_i       (out_rx_i),
    .in_i        (in_tok_i),
    .retry_i     (retry_i),
    .stall_req_i (stall_req_q),
    .flags_i     (flags_o),
    .hs_valid_o  (hs_valid_o),
    .hs_o        (hs),
    .set_o       (flag_set)
  );

  always_comb begin
    flag_wipe            = '0;
    flag_wipe[F_STALLED] = setup_rx_i;
  end

  usb_ep_flag_bank u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (flag_clr_i),
    .wipe_i (flag_wipe),
    .q_o    (flags_o)
  );

  // SETUP cancels the request ahead of any firmware write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          stall_req_q <= 1'b0;
    else if (setup_rx_i)  stall_req_q <= 1'b0;
    else if (stall_set_i) stall_req_q <= 1'b1;
    else if (stall_clr_i) stall_req_q <= 1'b0;
  end

  assign hs_o         = hs;
  assign stall_req_o  = stall_req_q;
  assign fifo_ctrl_o  = 1'b0;
  assign rw_allowed_o = 1'b0;
  assign irq_o        = |(flags_o & irq_en_i);

  assert_setup_ack_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_rx_i |-> hs_valid_o && hs_o == 2'b00);

  assert_setup_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_rx_i |=> flags_o[F_SETUP] && !stall_req_o && !flags_o[F_STALLED]);

  assert_setup_keeps_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_rx_i && !flag_clr_i[F_OUT] |=> flags_o[F_OUT] == $past(flags_o[F_OUT]));

  assert_retry_no_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_rx_i || in_tok_i) && !setup_rx_i && retry_i |-> hs_o == 2'b01);

  assert_stall_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o && hs_o == 2'b10 |=> flags_o[F_STALLED]);

  assert_busy_nak_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_rx_i && !setup_rx_i && (flags_o[F_SETUP] || flags_o[F_OUT]) |-> hs_o != 2'b00);

  assert_irq_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |flags_o);
endmodule

// File: tb/usb_ctrl_ep_hs_tb_top.sv
`timescale 1ns/1ps
module usb_ctrl_ep_hs_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic su = 0, o = 0, i = 0, rt = 0, ss = 0, sc = 0;
  logic [4:0] clr = '0, en = '0;
  logic hs_valid, sreq, fifo_c, rw_a, irq;
  logic [1:0] hs;
  logic [4:0] flags;

  int n_chk = 0, n_fail = 0;
  logic [1:0] q_hs[$];
  string q_tag[$];

  // bench model
  logic [4:0] m_flags = 5'b00100;
  logic m_sreq = 1'b0;

  always #2.5 clk = ~clk;

  usb_ctrl_ep_hs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .setup_rx_i(su), .out_rx_i(o), .in_tok_i(i),
    .retry_i(rt), .stall_set_i(ss), .stall_clr_i(sc), .flag_clr_i(clr),
    .irq_en_i(en), .hs_valid_o(hs_valid), .hs_o(hs), .flags_o(flags),
    .stall_req_o(sreq), .fifo_ctrl_o(fifo_c), .rw_allowed_o(rw_a), .irq_o(irq)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: drives one cycle, pushes expected handshake, updates model
  task automatic step(logic a_su, a_o, a_i, a_rt, a_ss, a_sc,
                      logic [4:0] a_clr, string tag);
    logic [1:0] e;
    logic [4:0] s;
    s = '0;
    e = 2'b00;
    @(negedge clk);
    su = a_su; o = a_o; i = a_i; rt = a_rt; ss = a_ss; sc = a_sc; clr = a_clr;
    if (a_su) begin
      e = 2'b00; s[0] = 1;
    end else if (a_o || a_i) begin
      if (a_rt) begin e = 2'b01; if (!a_o) s[3] = 1; end
      else if (m_sreq) begin e = 2'b10; s[4] = 1; end
      else if (a_o) begin
        if (m_flags[0] || m_flags[1]) e = 2'b01;
        else begin e = 2'b00; s[1] = 1; end
      end else if (m_flags[2]) begin e = 2'b01; s[3] = 1; end
      else begin e = 2'b11; s[2] = 1; end
    end
    if (a_su || a_o || a_i) begin q_hs.push_back(e); q_tag.push_back(tag); end
    m_flags = (m_flags & ~a_clr) | s;
    if (a_su) m_flags[4] = s[4];
    m_sreq = a_su ? 1'b0 : a_ss ? 1'b1 : a_sc ? 1'b0 : m_sreq;
    @(negedge clk);
    su = 0; o = 0; i = 0; rt = 0; ss = 0; sc = 0; clr = '0;
  endtask

  // monitor: pops expected handshakes as the design produces them
  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n && hs_valid) begin
      if (q_hs.size() == 0) chk("unexpected handshake", {6'd0, hs}, 8'hff);
      else begin
        string t;
        logic [1:0] e;
        t = q_tag.pop_front();
        e = q_hs.pop_front();
        chk(t, {6'd0, hs}, {6'd0, e});
      end
    end
  end

  task automatic chk_state(string tag);
    chk({tag, " flags"}, {3'd0, flags}, {3'd0, m_flags});
    chk({tag, " sreq"}, {7'd0, sreq}, {7'd0, m_sreq});
  endtask

  initial begin
    #(5.0 * 20000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 flags", {3'd0, flags}, 8'h04);
    chk("R10 sreq", {7'd0, sreq}, 8'h00);
    chk("R8 irq masked", {7'd0, irq}, 8'h00);
    chk("R9 fifo", {7'd0, fifo_c}, 8'h00);
    chk("R9 rw", {7'd0, rw_a}, 8'h00);

    step(0,1,0,0,0,0,5'b0, "R5 out ack");       chk_state("R5 a");
    step(0,1,0,0,0,0,5'b0, "R5 out busy nak");  chk_state("R5 b");
    step(0,0,0,0,0,0,5'b00010, "R7 clr out");   chk_state("R7 a");
    step(1,0,0,0,0,0,5'b0, "R1 setup ack");     chk_state("R2 a");
    step(0,1,0,0,0,0,5'b0, "R5 out nak setup"); chk_state("R5 c");
    step(0,0,0,0,0,0,5'b00001, "R7 clr setup"); chk_state("R7 b");
    step(0,0,1,0,0,0,5'b0, "R6 in nak");        chk_state("R6 a");
    step(0,0,0,0,0,0,5'b01100, "R7 clr inrdy"); chk_state("R7 c");
    step(0,0,1,0,0,0,5'b0, "R6 in data");       chk_state("R6 b");
    step(0,0,0,0,1,0,5'b0, "R7 stall set");     chk_state("R7 d");
    step(0,1,0,0,0,0,5'b0, "R4 out stall");     chk_state("R4 a");
    step(0,0,1,1,0,0,5'b0, "R3 in retry nak");  chk_state("R3 a");
    step(0,1,0,1,0,0,5'b0, "R3 out retry nak"); chk_state("R3 b");
    step(0,0,0,0,0,0,5'b11000, "R7 clr");       chk_state("R7 e");
    step(0,0,0,0,0,1,5'b0, "R7 stall clr");     chk_state("R7 f");
    step(0,1,0,0,0,0,5'b0, "R5 out ack 2");     chk_state("R5 d");
    step(0,0,0,0,1,0,5'b0, "R7 stall set 2");   chk_state("R7 g");
    step(0,0,1,0,0,0,5'b0, "R4 in stall");      chk_state("R4 b");
    // R2: setup with stall pending, stalled set, out flag set; retry too (R1)
    step(1,0,0,1,0,0,5'b0, "R1 setup ack under stall"); chk_state("R2 b");
    chk("R2 out kept", {7'd0, flags[1]}, 8'h01);
    chk("R2 sreq gone", {7'd0, sreq}, 8'h00);
    // R8 irq masking
    en = 5'b00000; #1; chk("R8 irq off", {7'd0, irq}, 8'h00);
    en = 5'b00010; #1; chk("R8 irq out", {7'd0, irq}, 8'h01);
    step(0,0,0,0,0,0,5'b00011, "R7 clr both");  chk_state("R7 h");
    chk("R8 irq cleared", {7'd0, irq}, 8'h00);
    // R7 set wins over clear; stall set beats stall clear
    step(0,1,0,0,1,1,5'b00010, "R7 out set vs clr"); chk_state("R7 i");
    chk("R8 irq again", {7'd0, irq}, 8'h01);
    // R1 simultaneous events: setup served
    step(1,1,1,0,0,0,5'b0, "R1 setup wins");    chk_state("R2 c");
    chk("R9 fifo end", {6'd0, fifo_c, rw_a}, 8'h00);
    chk("queue drained", q_hs.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule